// File: doc/BRIEF.md
# Memory-Based Fixed Delay Line

This block delays a stream of words by a fixed number of clock cycles. It does not pass the data along a chain of flip-flops. Each word is written once into a two-port storage array and stays at that location. A write pointer and a read pointer move through the array, one step per clock, and the distance between them sets the delay. For long delays this trades a large bank of flops for one array and two small counters.

The block accepts a new word on every rising clock edge. After a fixed latency it presents that word on a registered output. The delay equals the number of array locations: with a depth of `2**ADDR_W`, the block acts like a shift register of that many stages. After reset the output holds zero until the array has been filled once, so stale array contents are never seen on the output.

Top module: `sram_delay_line`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, the output is zero after that edge.
- R2: After reset is released, the output is zero for the first DEPTH-1 clock edges (DEPTH = 2**ADDR_W). Once the output has begun to carry data, it does not fall back to this zero-fill state without a reset.
- R3: From the edge with index DEPTH-1 after reset release, counting from 0, the output after edge k equals the input word sampled at edge k-(DEPTH-1). This is the behaviour of a DEPTH-stage shift register.
- R4: On the first edge after reset, the read pointer is at location 0 and the write pointer is at location DEPTH-1, its all-ones value.
- R5: Outside reset, both pointers advance by one location on every clock edge and wrap from DEPTH-1 to 0. The write pointer always stays one location behind the read pointer.
- R6: A reset during operation discards all buffered words. After the reset, the output is zero for DEPTH-1 edges even though the array still holds old data.
- R7: Every bit of the data word passes through unchanged, for any value including all zeros, all ones and alternating bit patterns.
- R8: Input words presented while reset is asserted are never delivered to the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W | Input word, sampled on every rising edge |
| dout | output | DATA_W | Registered output word, delayed by DEPTH stages |

## Verification
On every cycle, the assertions check how the pointers behave: their start values after reset, their step of one with wraparound, and the fixed gap between them. They also check that the zero-fill state ends only once per reset and that the output stays zero while it lasts. Only the bench scenarios can show that the right word emerges after exactly DEPTH stages. The bench compares the output with a reference queue across counting, random and alternating-bit streams. It also checks that a reset in the middle of a stream discards the buffered words, and that words driven during reset never reach the output.

// File: rtl/delay_line_pkg.sv
// Package: delay_line_pkg
// Shared defaults and a helper for the memory-based delay line.
// Assumes the depth is a power of two, given as an address width.
package delay_line_pkg;
    localparam int unsigned DL_DATA_W_DEF = 8;
    localparam int unsigned DL_ADDR_W_DEF = 4;

    // Number of stages for a given address width.
    function automatic int unsigned dl_depth(input int unsigned addr_w);
        return 32'd1 << addr_w;
    endfunction
endpackage

// File: rtl/dl_ptr_counter.sv
// Module: dl_ptr_counter
// Free-running address counter that steps by one location per clock.
// It wraps through all 2**ADDR_W locations. Reset loads START_VAL.
// Assumes a power-of-two range, so the wrap comes from the counter's natural overflow.
module dl_ptr_counter #(
    parameter int unsigned ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] START_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    // Load the start location on reset, otherwise move one location on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= START_VAL;
        end else begin
            ptr <= ptr + STEP;
        end
    end
endmodule

// File: rtl/dl_dual_port_ram.sv
// Module: dl_dual_port_ram
// Behavioural two-port array: one write port and one registered read port.
// If both ports use the same location in the same cycle, the read returns the old word.
// When rd_en is low, the read register loads zero instead of array data.
// Assumes one clock for both ports. The array itself has no reset.
module dl_dual_port_ram #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word while not in reset.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Register the addressed word; return zero while reads are not yet valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_addr];
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/dl_fill_tracker.sv
// Module: dl_fill_tracker
// Marks when the array has been filled once since reset.
// The read at location DEPTH-1 in the first lap is the first read of a word written
// after reset, so the flag is set there. From then on every read is valid.
// Assumes the read pointer starts at zero on reset.
module dl_fill_tracker #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic              filled
);
    localparam logic [ADDR_W-1:0] LAST_LOC = '1;

    // A read is valid once filled, or on the read that completes the first lap.
    always_comb begin
        rd_valid = filled || (rd_addr == LAST_LOC);
    end

    // The flag sets on the first valid read and stays set until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filled <= 1'b0;
        end else if (rd_valid) begin
            filled <= 1'b1;
        end
    end
endmodule

// File: rtl/sram_delay_line.sv
// Module: sram_delay_line
// Fixed delay of 2**ADDR_W stages, built from a two-port array and two pointers.
// The write pointer starts at the last location and the read pointer at the first.
// Both move one step per clock, so a stored word is read back DEPTH-1 edges after
// it was written, and the registered output adds the last stage.
// Assumes a single clock and a synchronous active-low reset.
module sram_delay_line
    import delay_line_pkg::*;
#(
    parameter int unsigned DATA_W = DL_DATA_W_DEF,
    parameter int unsigned ADDR_W = DL_ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam logic [ADDR_W-1:0] RD_START = '0;
    localparam logic [ADDR_W-1:0] WR_START = '1;

    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] wr_addr;
    logic              rd_valid;
    logic              filled_q;

    dl_ptr_counter #(.ADDR_W(ADDR_W), .START_VAL(RD_START)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (rd_addr)
    );

    dl_ptr_counter #(.ADDR_W(ADDR_W), .START_VAL(WR_START)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (wr_addr)
    );

    dl_fill_tracker #(.ADDR_W(ADDR_W)) u_fill (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .filled   (filled_q)
    );

    dl_dual_port_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_en   (rd_valid),
        .rd_data (dout)
    );
endmodule

// File: rtl/sram_delay_line_checker.sv
// Module: sram_delay_line_checker
// Cycle-by-cycle properties of the delay line's pointers and zero-fill state.
// Bound into every instance of sram_delay_line.
module sram_delay_line_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              filled_q,
    input logic [DATA_W-1:0] dout
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // R4: pointer start values on the first edge after reset
    assert_ptr_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rd_addr == '0) && (wr_addr == '1));

    // R5: read pointer steps by one with wrap
    assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rd_addr == $past(rd_addr) + ONE);

    // R5: write pointer trails read pointer by one location
    assert_ptr_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr + ONE == rd_addr);

    // R1: output is zero right after a reset edge
    assert_reset_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> dout == '0);

    // R2: output stays zero while still filling
    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !filled_q |-> dout == '0);

    // R2: filled state never drops without reset
    assert_filled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        filled_q |=> filled_q);
endmodule

bind sram_delay_line sram_delay_line_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr),
    .filled_q (filled_q),
    .dout     (dout)
);

// File: tb/test_sram_delay_line.sv
// Scoreboard bench: the driver queues each word it presents, and the monitor
// compares the output with the queue head once DEPTH words are held.
module test_sram_delay_line;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DEPTH  = 1 << ADDR_W;
    localparam time CLK_P = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DATA_W-1:0] din = '0;
    logic [DATA_W-1:0] dout;

    int n_checks = 0;
    int n_fail   = 0;
    bit mid_reset_seen = 1'b0;
    bit running = 1'b0;
    logic [DATA_W-1:0] exp_q [$];

    sram_delay_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_sram_delay_line (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .dout  (dout)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: dout=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: present one word on the falling edge and record it as expected.
    task automatic send(input logic [DATA_W-1:0] v);
        @(negedge clk);
        rst_n = 1'b1;
        din = v;
        exp_q.push_back(v);
    endtask

    // Hold reset for n edges while junk words are driven (R8).
    task automatic hold_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0;
            din = DATA_W'(8'hC3 ^ i);
            exp_q.delete();
        end
    endtask

    // Monitor: a quarter period after each rising edge, compare with the scoreboard.
    always begin
        @(posedge clk);
        #(CLK_P/4);
        if (running) begin
            if (!rst_n) begin
                check(dout == '0, "R1", dout, '0);
            end else if (exp_q.size() >= DEPTH) begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                // R3 delay of DEPTH stages; R4 R5 pointer placement; R7 R8 data integrity
                check(dout === e, mid_reset_seen ? "R3 R6 R8" : "R3 R4 R5 R7", dout, e);
            end else begin
                check(dout == '0, mid_reset_seen ? "R6 R2" : "R2", dout, '0);
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: dout=%h expected=end of run", dout);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        running = 1'b1;
        hold_reset(3);
        // Counting stream
        for (int i = 0; i < 40; i++) send(DATA_W'(i + 1));
        // Random stream
        for (int i = 0; i < 50; i++) send(DATA_W'($urandom));
        // Mid-run reset with old data left in the array
        hold_reset(2);
        mid_reset_seen = 1'b1;
        // Bit-pattern stream (R7)
        for (int i = 0; i < 48; i++) begin
            case (i % 4)
                0: send('1);
                1: send('0);
                2: send({(DATA_W/2){2'b10}});
                default: send({(DATA_W/2){2'b01}});
            endcase
        end
        @(negedge clk);
        @(negedge clk);
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule